// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a small set of hardware tokens that two independent ports, called left and right, use to claim shared resources without racing each other. Each token is a latch that is free, held by the left port, or held by the right port. A port claims a token by writing a request, and then reads the token back to learn whether it now holds it. If the other port already holds the token, the request waits and is granted without further action once the holder gives the token back.

Each port has active-low controls for chip enable, token enable, write and output enable, plus a token index and a data word. A token access needs the token enable low while the chip enable stays high. Holding both low at once is a fault. The fault raises an error flag and changes nothing. All state changes take place on the rising clock edge. The read data is combinational and reflects the registered state.

Top module: `sem_bank`

## Requirements
- R1: A token access on a port needs sem_n=0 and cs_n=1. The token is chosen by the index `addr` (0..7). With sem_n=1 the port has no effect on any token, whatever cs_n and we_n are.
- R2: A write (we_n=0 during a token access) looks only at bit 0 of `wdata`. 0 is a request and 1 is a release. Bits 7..1 are ignored.
- R3: A request on a free token makes the requesting port its holder at the next rising edge.
- R4: When sem_n=0, cs_n=1, we_n=1 and oe_n=0, `rd_en` is 1 and all eight bits of `rdata` are 0 if this port holds the indexed token, or all 1 if it does not. Otherwise `rd_en` is 0 and `rdata` is 0.
- R5: No token is ever held by both ports at once.
- R6: A request on a token held by the other port stays pending. It is granted on the same edge at which the holder releases that token.
- R7: When both ports request the same free token in the same cycle, the left port is granted and the right request stays pending.
- R8: A release from a port that does not hold the token cancels that port's pending request and leaves the holder unchanged.
- R9: cs_n=0 together with sem_n=0 on a port sets that port's `err` to 1 for the cycle after the edge and changes no token. Otherwise `err` is 0.
- R10: After reset every token is free, no request is pending and both `err` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left chip enable, active low (must be high for token access) |
| l_sem_n | input | 1 | Left token enable, active low |
| l_we_n | input | 1 | Left write, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left token index |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data |
| l_rd_en | output | 1 | Left read data is driven |
| l_err | output | 1 | Left illegal-enable flag |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_sem_n | input | 1 | Right token enable, active low |
| r_we_n | input | 1 | Right write, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right token index |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data |
| r_rd_en | output | 1 | Right read data is driven |
| r_err | output | 1 | Right illegal-enable flag |

## Verification
The bench goes after the hand-over edge: a design that granted a pending request one cycle late, or dropped it, would show the waiting port still reading all ones after the holder's release. It checks simultaneous requests, where a design with no fixed priority would give the token to both ports or to neither. It checks a release from a port that does not hold the token, which a faulty design would either ignore, so that the stale request is granted later, or let free the other port's token. It also checks the illegal enable combination, which must not sneak a request in, and a reset taken while a request is pending, which must not leave a grant behind.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_owner_e;

    typedef struct packed {
        tok_owner_e owner;
        logic       pend_l;
        logic       pend_r;
    } tok_state_t;

    typedef struct packed {
        logic err_l;
        logic err_r;
    } err_state_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 cs_n,
    input  logic                 sem_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [IDX_W-1:0]     addr,
    input  logic                 wbit,
    input  logic [NUM_FLAGS-1:0] held,
    output logic [NUM_FLAGS-1:0] req_oh,
    output logic [NUM_FLAGS-1:0] rel_oh,
    output logic                 illegal,
    output logic                 rd_en,
    output logic [DATA_W-1:0]    rdata
);
    logic legal;
    logic wr;

    always_comb begin
        legal   = !sem_n && cs_n;
        illegal = !sem_n && !cs_n;
        wr      = legal && !we_n;
        rd_en   = legal && we_n && !oe_n;
        rdata   = rd_en ? {DATA_W{!held[addr]}} : '0;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sel
        assign req_oh[i] = wr && !wbit && (addr == IDX_W'(i));
        assign rel_oh[i] = wr &&  wbit && (addr == IDX_W'(i));
    end
endmodule

// File: rtl/sem_tok_cell.sv
module sem_tok_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r
);
    tok_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rel_l) begin
            if (st_d.owner == TOK_LEFT) st_d.owner = TOK_FREE;
            st_d.pend_l = 1'b0;
        end
        if (rel_r) begin
            if (st_d.owner == TOK_RIGHT) st_d.owner = TOK_FREE;
            st_d.pend_r = 1'b0;
        end
        if (req_l && st_d.owner != TOK_LEFT)  st_d.pend_l = 1'b1;
        if (req_r && st_d.owner != TOK_RIGHT) st_d.pend_r = 1'b1;
        if (st_d.owner == TOK_FREE) begin
            if (st_d.pend_l) begin
                st_d.owner  = TOK_LEFT;
                st_d.pend_l = 1'b0;
            end else if (st_d.pend_r) begin
                st_d.owner  = TOK_RIGHT;
                st_d.pend_r = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{owner: TOK_FREE, pend_l: 1'b0, pend_r: 1'b0};
        else        st_q <= st_d;
    end

    assign own_l = (st_q.owner == TOK_LEFT);
    assign own_r = (st_q.owner == TOK_RIGHT);
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_sem_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [IDX_W-1:0]  l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rd_en,
    output logic              l_err,
    input  logic              r_cs_n,
    input  logic              r_sem_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [IDX_W-1:0]  r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rd_en,
    output logic              r_err
);
    logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec;
    logic [NUM_FLAGS-1:0] req_l_oh, rel_l_oh, req_r_oh, rel_r_oh;
    logic                 ill_l, ill_r;
    err_state_t           err_d, err_q;

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_l (
        .cs_n(l_cs_n), .sem_n(l_sem_n), .we_n(l_we_n), .oe_n(l_oe_n),
        .addr(l_addr), .wbit(l_wdata[0]), .held(own_l_vec),
        .req_oh(req_l_oh), .rel_oh(rel_l_oh), .illegal(ill_l),
        .rd_en(l_rd_en), .rdata(l_rdata)
    );

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_r (
        .cs_n(r_cs_n), .sem_n(r_sem_n), .we_n(r_we_n), .oe_n(r_oe_n),
        .addr(r_addr), .wbit(r_wdata[0]), .held(own_r_vec),
        .req_oh(req_r_oh), .rel_oh(rel_r_oh), .illegal(ill_r),
        .rd_en(r_rd_en), .rdata(r_rdata)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_tok
        sem_tok_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(req_l_oh[i]), .rel_l(rel_l_oh[i]),
            .req_r(req_r_oh[i]), .rel_r(rel_r_oh[i]),
            .own_l(own_l_vec[i]), .own_r(own_r_vec[i])
        );
    end

    always_comb begin
        err_d.err_l = ill_l;
        err_d.err_r = ill_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign l_err = err_q.err_l;
    assign r_err = err_q.err_r;
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_cs_n,
    input logic                 l_sem_n,
    input logic                 l_we_n,
    input logic [IDX_W-1:0]     l_addr,
    input logic [DATA_W-1:0]    l_wdata,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 l_rd_en,
    input logic                 l_err,
    input logic                 r_sem_n,
    input logic [NUM_FLAGS-1:0] own_l_vec,
    input logic [NUM_FLAGS-1:0] own_r_vec
);
    assert_mutex_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l_vec & own_r_vec) == '0);

    assert_rd_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd_en |-> (l_rdata == '0 || l_rdata == '1));

    assert_no_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd_en |-> (l_rdata == '0));

    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && !l_sem_n) |=> l_err);

    assert_illegal_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && !l_sem_n && r_sem_n) |=> ($stable(own_l_vec) && $stable(own_r_vec)));

    assert_grant_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cs_n && !l_sem_n && !l_we_n && !l_wdata[0] && r_sem_n && !own_r_vec[l_addr])
        |=> own_l_vec[$past(l_addr)]);

    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cs_n && !l_sem_n && !l_we_n && l_wdata[0]) |=> !own_l_vec[$past(l_addr)]);
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_rd_en(l_rd_en), .l_err(l_err), .r_sem_n(r_sem_n),
    .own_l_vec(own_l_vec), .own_r_vec(own_r_vec)
);

// File: tb/sem_bank_bench.sv
`timescale 1ns/1ps
module sem_bank_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       l_cs_n, l_sem_n, l_we_n, l_oe_n, r_cs_n, r_sem_n, r_we_n, r_oe_n;
    logic [2:0] l_addr, r_addr;
    logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic       l_rd_en, r_rd_en, l_err, r_err;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sem_bank u_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_rd_en(l_rd_en), .l_err(l_err),
        .r_cs_n(r_cs_n), .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_rd_en(r_rd_en), .r_err(r_err)
    );

    // port field: {cs_n, sem_n, we_n, oe_n, addr[2:0], wdata[7:0]}
    function automatic logic [14:0] pk(logic cs, logic sm, logic we, logic oe,
                                       logic [2:0] a, logic [7:0] d);
        return {cs, sm, we, oe, a, d};
    endfunction
    function automatic logic [14:0] idl();
        return pk(1, 1, 1, 1, 3'd0, 8'h00);
    endfunction
    function automatic logic [14:0] rd(logic [2:0] a);
        return pk(1, 0, 1, 0, a, 8'h00);
    endfunction
    function automatic logic [14:0] wr(logic [2:0] a, logic [7:0] d);
        return pk(1, 0, 0, 1, a, d);
    endfunction
    function automatic logic [51:0] v(logic [3:0] tag, logic [14:0] lp, logic [14:0] rp,
                                      logic [7:0] el, logic [7:0] er, logic eel, logic eer);
        return {tag, lp, rp, el, er, eel, eer};
    endfunction

    // {req tag, left, right, exp l_rdata, exp r_rdata, exp l_err, exp r_err}
    // rdata is checked before the edge, err after it
    localparam int NV = 22;
    localparam logic [51:0] VEC [NV] = '{
        v(2,  wr(3, 8'hFE), rd(3),      8'h00, 8'hFF, 0, 0), // R2 request, upper bits ignored
        v(3,  rd(3),        rd(3),      8'h00, 8'hFF, 0, 0), // R3 left holds 3
        v(6,  rd(3),        wr(3, 0),   8'h00, 8'h00, 0, 0), // R6 right pending
        v(6,  idl(),        rd(3),      8'h00, 8'hFF, 0, 0), // R6 still pending
        v(6,  wr(3, 8'h01), rd(3),      8'h00, 8'hFF, 0, 0), // R6 left releases
        v(6,  rd(3),        rd(3),      8'hFF, 8'h00, 0, 0), // R6 granted at release edge
        v(7,  wr(5, 0),     wr(5, 0),   8'h00, 8'h00, 0, 0), // R7 simultaneous
        v(7,  rd(5),        rd(5),      8'h00, 8'hFF, 0, 0), // R7 left wins
        v(7,  wr(5, 1),     rd(5),      8'h00, 8'hFF, 0, 0), // R7 left releases
        v(7,  idl(),        rd(5),      8'h00, 8'h00, 0, 0), // R7 right pending granted
        v(8,  wr(3, 0),     idl(),      8'h00, 8'h00, 0, 0), // R8 left pends on 3
        v(8,  wr(3, 1),     rd(3),      8'h00, 8'h00, 0, 0), // R8 non-holder release
        v(8,  rd(3),        rd(3),      8'hFF, 8'h00, 0, 0), // R8 holder unchanged
        v(8,  idl(),        wr(3, 1),   8'h00, 8'h00, 0, 0), // R8 right releases
        v(8,  rd(3),        rd(3),      8'hFF, 8'hFF, 0, 0), // R8 no stale grant
        v(9,  pk(0, 0, 0, 1, 3'd6, 8'h00), rd(6), 8'h00, 8'hFF, 1, 0), // R9 illegal
        v(9,  rd(6),        rd(6),      8'hFF, 8'hFF, 0, 0), // R9 nothing written
        v(1,  wr(7, 0),     wr(0, 0),   8'h00, 8'h00, 0, 0), // R1 index select
        v(1,  rd(7),        rd(0),      8'h00, 8'h00, 0, 0), // R1 each holds own
        v(5,  rd(0),        rd(7),      8'hFF, 8'hFF, 0, 0), // R5 not the other's
        v(1,  pk(0, 1, 0, 1, 3'd1, 8'h00), pk(0, 1, 0, 0, 3'd0, 8'h01), 8'h00, 8'h00, 0, 0), // R1 sem_n high
        v(4,  pk(1, 0, 1, 1, 3'd0, 8'h00), rd(1), 8'h00, 8'hFF, 0, 0)  // R4 oe_n high, R1 flag 1 free
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_l(logic [14:0] p);
        {l_cs_n, l_sem_n, l_we_n, l_oe_n, l_addr, l_wdata} = p;
    endtask
    task automatic put_r(logic [14:0] p);
        {r_cs_n, r_sem_n, r_we_n, r_oe_n, r_addr, r_wdata} = p;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        put_l(idl());
        put_r(idl());
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", {6'd0, l_err, r_err}, 8'h00, "err in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d", VEC[i][51:48]);
            put_l(VEC[i][47:33]);
            put_r(VEC[i][32:18]);
            #1;
            chk(tg, l_rdata, VEC[i][17:10], $sformatf("vec %0d l_rdata", i));
            chk(tg, r_rdata, VEC[i][9:2], $sformatf("vec %0d r_rdata", i));
            @(posedge clk);
            #1;
            chk(tg, {7'd0, l_err}, {7'd0, VEC[i][1]}, $sformatf("vec %0d l_err", i));
            chk(tg, {7'd0, r_err}, {7'd0, VEC[i][0]}, $sformatf("vec %0d r_err", i));
            @(negedge clk);
        end
        // R9 on the right port, err drops after one cycle
        put_l(idl());
        put_r(pk(0, 0, 0, 1, 3'd2, 8'h00));
        @(posedge clk); #1;
        chk("R9", {7'd0, r_err}, 8'h01, "right err");
        @(negedge clk);
        put_r(idl());
        @(posedge clk); #1;
        chk("R9", {7'd0, r_err}, 8'h00, "right err clears");
        @(negedge clk);
        // R10: left holds 2, right pends on 2, then reset
        put_l(wr(2, 0));
        put_r(wr(2, 0));
        @(negedge clk);
        put_l(idl());
        put_r(idl());
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int f = 0; f < 8; f++) begin
            put_l(rd(3'(f)));
            put_r(rd(3'(f)));
            #1;
            chk("R10", l_rdata, 8'hFF, $sformatf("left flag %0d after reset", f));
            chk("R10", r_rdata, 8'hFF, $sformatf("right flag %0d after reset", f));
            @(negedge clk);
        end
        // R3 right grant on a free flag after reset
        put_l(idl());
        put_r(wr(4, 8'h00));
        @(negedge clk);
        put_r(rd(4));
        #1;
        chk("R3", r_rdata, 8'h00, "right grant flag 4");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule